// File: doc/BRIEF.md
# Test Access Port Controller with Parity-Checked Instruction Register

This block is the serial test port of a chip. It follows the standard sixteen-state test access port state machine, driven by the test clock and the mode-select line. It holds an 8-bit instruction register and routes one of three data paths between the serial input and the serial output. The three paths are a one-bit bypass stage, a 32-bit identification register, and an external data-register chain that sits outside this block. The external chain is driven through capture, shift and update strobes and returns its serial bit on a dedicated input.

Every instruction carries an even-parity bit in its top bit. The decoder treats any opcode with an odd number of ones as bypass. It also treats every even-parity opcode it does not know as bypass. A test-mode output tells the surrounding logic when the current instruction takes over the normal pins. A separate output asks the pin drivers to float their outputs. Inputs are sampled on the rising test-clock edge. The serial output, its enable and the active instruction change on the falling edge.

Top module: `scan_port_ctrl`

## Requirements
- R1: The state machine moves on each rising edge of `tck` according to `tms`, using the standard sixteen-state graph. Five consecutive rising edges with `tms` high bring it to the reset state from any state.
- R2: While `rst` is high on a rising edge, and whenever the controller is in the reset state, the active instruction becomes 10000001 (identification). A data scan entered straight after reset shifts out the 32-bit ID value LSB first.
- R3: In the capture-instruction state, the instruction shift register loads 10000001. An instruction scan therefore returns those bits, bit 0 first.
- R4: `tdo_en` rises on the first falling edge after entering either shift state, and `tdo` then shows bit 0 of the selected register. `tdo_en` falls on the first falling edge after entering either exit-1 state.
- R5: Shifting happens on the rising edge while the controller is in a shift state. `tdi` enters at the MSB and the LSB leaves on `tdo`. No shift happens on the edge that enters the shift state. The bypass stage captures 0, so a bypass scan returns 0 followed by `tdi` delayed by one bit.
- R6: A newly shifted instruction takes effect on the falling edge in the update-instruction state. Before that edge, and in the exit-1 state, the previous instruction's outputs still hold.
- R7: The decoder maps these opcodes as follows:
  - 11111111 is bypass, with `test_mode` 0.
  - 10000001 is identification, with `test_mode` 0.
  - 00000000 drives the external path with `sel_ext` 1 and `test_mode` 1.
  - 10000010 observes through the external path with `sel_ext` 1 and `test_mode` 0.
  - 00000110 is bypass with `test_mode` 1 and `outs_off` 1.
- R8: Any opcode with an odd count of ones decodes as bypass, with `test_mode`, `outs_off` and `sel_ext` all 0.
- R9: Any even-parity opcode not listed in R7 decodes as bypass, with `test_mode`, `outs_off` and `sel_ext` all 0.
- R10: `test_mode` and `outs_off` are 0 whenever the controller is in the reset state.
- R11: `capture_dr`, `shift_dr` and `update_dr` are high exactly while the controller is in the capture-data, shift-data and update-data states. An external chain selected by `sel_ext` scans through `ext_tdo` with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, steers the state machine |
| tdi | input | 1 | Serial data in |
| ext_tdo | input | 1 | Serial bit returned by the external data chain |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |
| capture_dr | output | 1 | High in the capture-data state |
| shift_dr | output | 1 | High in the shift-data state |
| update_dr | output | 1 | High in the update-data state |
| sel_ext | output | 1 | External chain is the selected data path |
| test_mode | output | 1 | Current instruction takes over the normal pins |
| outs_off | output | 1 | Current instruction floats the pin outputs |

## Verification
The bench walks a table of opcodes that covers the supported instructions, odd-parity words and unknown even-parity words. For each opcode it compares the full data scan against the shape it expects. A decoder that ignored parity would send the external chain's bits, or the ID value, where a delayed copy of `tdi` belongs. An off-by-one shift would misalign every returned word. The bench samples `test_mode` in the exit-1 state to catch an instruction that takes effect early. It also leaves a test-mode instruction loaded, enters a data scan and holds `tms` high five times. A controller that needed more steps to reach reset, or that kept `test_mode` high there, would be caught.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_EXT = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     tmode;
        logic     outs_off;
    } op_dec_t;

    localparam logic [IR_W-1:0] OP_BYPASS = 8'b1111_1111;
    localparam logic [IR_W-1:0] OP_IDENT  = 8'b1000_0001;
    localparam logic [IR_W-1:0] OP_DRIVE  = 8'b0000_0000;
    localparam logic [IR_W-1:0] OP_OBSERVE = 8'b1000_0010;
    localparam logic [IR_W-1:0] OP_FLOAT  = 8'b0000_0110;
    localparam logic [IR_W-1:0] IR_FIXED  = 8'b1000_0001;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        unique case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            default:   n = m ? ST_SEL_DR : ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic op_dec_t op_decode(logic [IR_W-1:0] op);
        op_dec_t d;
        d = '{path: PATH_BYP, tmode: 1'b0, outs_off: 1'b0};
        if (^op == 1'b0) begin
            unique case (op)
                OP_IDENT:   d.path = PATH_ID;
                OP_DRIVE:   begin d.path = PATH_EXT; d.tmode = 1'b1; end
                OP_OBSERVE: d.path = PATH_EXT;
                OP_FLOAT:   begin d.tmode = 1'b1; d.outs_off = 1'b1; end
                default:    d = d;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    // R1
    reset_walk_chk: assert property (@(posedge tck) disable iff (rst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_RESET));

    // R1
    reset_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/scan_instr_reg.sv
module scan_instr_reg
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       ir_tdo,
    output op_dec_t    dec
);

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] act_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            sh_q <= IR_FIXED;
        end else if (state == ST_CAP_IR) begin
            sh_q <= IR_FIXED;
        end else if (state == ST_SH_IR) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    always_ff @(negedge tck) begin
        if (rst || state == ST_RESET) act_q <= IR_FIXED;
        else if (state == ST_UPD_IR)  act_q <= sh_q;
    end

    assign ir_tdo = sh_q[0];
    assign dec    = op_decode(act_q);

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_IR) |=> (sh_q == IR_FIXED));

    // R8
    odd_parity_chk: assert property (@(posedge tck) disable iff (rst)
        (^act_q) |-> (dec.path == PATH_BYP && !dec.tmode && !dec.outs_off));

endmodule

// File: rtl/scan_data_regs.sv
module scan_data_regs
    import scan_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       ir_tdo,
    input  logic       ext_tdo,
    output logic       tdo,
    output logic       tdo_en
);

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            dr_bit;
    logic            in_shift;

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= ID_VAL;
        end else begin
            unique case (state)
                ST_CAP_DR: begin
                    byp_q <= 1'b0;
                    id_q  <= ID_VAL;
                end
                ST_SH_DR: begin
                    byp_q <= tdi;
                    id_q  <= {tdi, id_q[ID_W-1:1]};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (path)
            PATH_ID:  dr_bit = id_q[0];
            PATH_EXT: dr_bit = ext_tdo;
            default:  dr_bit = byp_q;
        endcase
    end

    assign in_shift = (state == ST_SH_IR) || (state == ST_SH_DR);

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= in_shift;
            if (in_shift) tdo <= (state == ST_SH_IR) ? ir_tdo : dr_bit;
        end
    end

    // R4
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R5
    byp_shift_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_SH_DR) |=> (byp_q == $past(tdi)));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h2B61_904D
) (
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    input  logic ext_tdo,
    output logic tdo,
    output logic tdo_en,
    output logic capture_dr,
    output logic shift_dr,
    output logic update_dr,
    output logic sel_ext,
    output logic test_mode,
    output logic outs_off
);

    tap_state_e state;
    op_dec_t    dec;
    logic       ir_tdo;
    logic       active;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    scan_instr_reg u_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state),
        .ir_tdo (ir_tdo),
        .dec    (dec)
    );

    scan_data_regs #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
        .tck     (tck),
        .rst     (rst),
        .tdi     (tdi),
        .state   (state),
        .path    (dec.path),
        .ir_tdo  (ir_tdo),
        .ext_tdo (ext_tdo),
        .tdo     (tdo),
        .tdo_en  (tdo_en)
    );

    assign active     = (state != ST_RESET);
    assign capture_dr = (state == ST_CAP_DR);
    assign shift_dr   = (state == ST_SH_DR);
    assign update_dr  = (state == ST_UPD_DR);
    assign sel_ext    = (dec.path == PATH_EXT);
    assign test_mode  = dec.tmode & active;
    assign outs_off   = dec.outs_off & active;

    // R6
    instr_effect_chk: assert property (@(posedge tck) disable iff (rst)
        $rose(test_mode) |-> (state == ST_UPD_IR));

    // R10
    reset_quiet_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET && $past(state) == ST_RESET) |-> (!test_mode && !outs_off));

endmodule

// File: tb/scan_port_ctrl_bench.sv
module scan_port_ctrl_bench;

    localparam int          CLK_P   = 10;
    localparam logic [31:0] ID_VAL  = 32'h2B61_904D;
    localparam logic [32:0] EXT_CAP = 33'h1_3C5A_96E1;
    localparam int          NBITS   = 33;
    // op[11:4], path[3:2] (0 bypass, 1 id, 2 external), test_mode[1], outs_off[0]
    localparam logic [11:0] VEC [8] = '{
        {8'b1111_1111, 2'd0, 1'b0, 1'b0},
        {8'b1000_0001, 2'd1, 1'b0, 1'b0},
        {8'b0000_0000, 2'd2, 1'b1, 1'b0},
        {8'b1000_0010, 2'd2, 1'b0, 1'b0},
        {8'b0000_0110, 2'd0, 1'b1, 1'b1},
        {8'b0000_0001, 2'd0, 1'b0, 1'b0},
        {8'b1000_0000, 2'd0, 1'b0, 1'b0},
        {8'b0001_0001, 2'd0, 1'b0, 1'b0}
    };

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic ext_tdo;
    logic tdo, tdo_en, capture_dr, shift_dr, update_dr, sel_ext, test_mode, outs_off;
    logic [32:0] ext_chain = '0;
    int n_chk = 0;
    int n_fail = 0;
    logic strobe_ok = 1'b1;
    logic en_ok = 1'b1;
    bit done = 1'b0;

    always #(CLK_P/2) tck = ~tck;

    always_ff @(posedge tck) begin
        if (capture_dr && sel_ext)    ext_chain <= EXT_CAP;
        else if (shift_dr && sel_ext) ext_chain <= {tdi, ext_chain[32:1]};
    end
    assign ext_tdo = ext_chain[0];

    scan_port_ctrl #(.ID_W(32), .ID_VAL(ID_VAL)) u_scan_port_ctrl (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .ext_tdo(ext_tdo),
        .tdo(tdo), .tdo_en(tdo_en), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .sel_ext(sel_ext), .test_mode(test_mode), .outs_off(outs_off)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1;
        o = tdo;
        e = tdo_en;
        tms = m;
        tdi = d;
    endtask

    task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap, output logic tm_pre);
        logic o, e;
        step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], o, e);
            cap[i] = o;
            if (!e) en_ok = 1'b0;
        end
        step(1'b1, 1'b0, o, e);
        if (e) en_ok = 1'b0;
        tm_pre = test_mode;
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic dr_scan(input logic [32:0] din, output logic [32:0] dout);
        logic o, e;
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        if (!capture_dr) strobe_ok = 1'b0;
        for (int i = 0; i < NBITS; i++) begin
            step(i == NBITS - 1, din[i], o, e);
            dout[i] = o;
            if (!e || !shift_dr) strobe_ok = 1'b0;
        end
        step(1'b1, 1'b0, o, e);
        if (e) en_ok = 1'b0;
        step(1'b0, 1'b0, o, e);
        if (!update_dr) strobe_ok = 1'b0;
    endtask

    function automatic logic [32:0] exp_dr(logic [1:0] p, logic [32:0] din);
        logic [32:0] r;
        if (p == 2'd1)      r = {din[0], ID_VAL};
        else if (p == 2'd2) r = EXT_CAP;
        else                r = {din[31:0], 1'b0};
        return r;
    endfunction

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  cap;
        logic [32:0] dout, din;
        logic        tm_pre, prev_tm, o, e;
        repeat (3) @(posedge tck);
        @(negedge tck);
        #1 rst = 1'b0;
        // R2 R10 reset state
        check(!tdo_en && !test_mode && !outs_off, "R2", "reset outputs",
              {tdo_en, test_mode, outs_off}, 0);
        step(1'b0, 1'b0, o, e);
        din = 33'h0_F0F0_1234;
        dr_scan(din, dout);
        // R2 R5 identification after reset, no shift on entry
        check(dout == {din[0], ID_VAL}, "R2", "id after reset", dout, {din[0], ID_VAL});

        prev_tm = 1'b0;
        for (int v = 0; v < 8; v++) begin
            logic [7:0] op;
            logic [1:0] p;
            logic tm, hz;
            {op, p, tm, hz} = VEC[v];
            ir_scan(op, cap, tm_pre);
            check(cap == 8'b1000_0001, "R3", "ir capture", cap, 8'b1000_0001);
            check(tm_pre == prev_tm, "R6", "test_mode before update", tm_pre, prev_tm);
            // R7 R8 R9 decode
            check(test_mode == tm && outs_off == hz && sel_ext == (p == 2'd2),
                  v < 5 ? "R7" : (v < 7 ? "R8" : "R9"), "decode flags",
                  {test_mode, outs_off, sel_ext}, {tm, hz, p == 2'd2});
            din = {v[0], 32'hC3A5_9617 ^ (32'(v) * 32'h1111_0101)};
            dr_scan(din, dout);
            check(dout == exp_dr(p, din), v < 5 ? "R7" : (v < 7 ? "R8" : "R9"),
                  "data scan (R5 R11)", dout, exp_dr(p, din));
            prev_tm = tm;
        end
        check(en_ok, "R4", "tdo_en in shift and exit1", en_ok, 1);
        check(strobe_ok, "R11", "dr strobes", strobe_ok, 1);

        // R1 R10 five tms-high edges from shift-data reach reset
        ir_scan(8'b0000_0000, cap, tm_pre);
        check(test_mode, "R7", "drive instr loaded", test_mode, 1);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        check(!test_mode && !outs_off, "R10", "test_mode in reset", test_mode, 0);
        check(!tdo_en, "R1", "tdo_en after reset walk", tdo_en, 0);
        step(1'b0, 1'b0, o, e);
        din = 33'h1_0000_5555;
        dr_scan(din, dout);
        check(dout == {din[0], ID_VAL}, "R1", "id after five tms-high", dout, {din[0], ID_VAL});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule